// File: doc/BRIEF.md
# Configuration Bitstream Command Queue and Read DMA

This block accepts transfer commands from software, keeps them in a small queue, and runs a word-reading DMA. The DMA fetches a bitstream from memory and streams it, one 32-bit word at a time, into a configuration port. Software builds each command with four register writes, one for each field. The fourth write pushes the finished command into the queue.

The engine takes one command at a time from the queue. It issues word reads on a single-outstanding request/acknowledge memory interface and presents each returned word on a valid/ready stream. The lowest bit of the source address is not part of the address: it flags the command as the final one of an image. A normal command raises a DMA-done pulse once its last read has returned. A final command instead raises a drain-done pulse, and only after the port has accepted its last word.

Malformed commands and pushes into a full queue are dropped and reported with an error pulse. After either error the engine stops taking new commands until reset. A transfer already in flight cannot be aborted, so it runs to completion.

Top module: `bitload_cmdq`

## Requirements
- R1: A command field is written with `reg_wr_en` high and `reg_wr_sel` giving the field: 0 = source address, 1 = destination address, 2 = source length, 3 = destination length. Writes with select 0, 1 and 2 only stage values, and the last written value of each field is used. Only a select-3 write pushes a command.
- R2: The source length counts 32-bit words. A command with source address A (bit 0 cleared for addressing) and length N issues N reads at byte addresses A, A+4, …, A+4(N−1), always word aligned. It emits the N returned words unchanged on the configuration stream.
- R3: `status_o` bit 31 is 1 exactly when the queue is full, and bit 30 is 1 exactly when it is empty. Bits 29..0 read zero. After reset the value is 0x4000_0000.
- R4: The queue holds DEPTH commands (default 4). A push while the queue is full is dropped and pulses `evt_ovf_err` for one cycle.
- R5: A command is dropped and `evt_fmt_err` pulses if any of these holds: source address bits 2..1 are not zero (not 8-byte aligned), the destination address is not all ones, the destination length is not zero, or the source length is zero.
- R6: After any error pulse, `halted_o` goes to 1 and stays there until reset. No further command is started, and a transfer already running still completes.
- R7: A command with source address bit 0 clear pulses `evt_dma_done` once, after its final read data has returned. It never raises `evt_drain_done`.
- R8: A command with source address bit 0 set pulses `evt_drain_done` once, after its final word has been accepted on the stream. It never raises `evt_dma_done`.
- R9: While `mem_rd_req` is high and not acknowledged, the request and its address hold. While `cfg_valid` is high and `cfg_ready` is low, the valid and the data hold.
- R10: Commands are carried out in push order, and words across commands leave in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Field write strobe |
| reg_wr_sel | input | 2 | Field select (0 src addr, 1 dst addr, 2 src len, 3 dst len) |
| reg_wr_data | input | DATA_W | Field write value |
| status_o | output | DATA_W | Bit 31 queue full, bit 30 queue empty |
| halted_o | output | 1 | Engine stopped after an error |
| evt_dma_done | output | 1 | Pulse: non-final command fetched |
| evt_drain_done | output | 1 | Pulse: final command fully accepted by port |
| evt_ovf_err | output | 1 | Pulse: push into full queue dropped |
| evt_fmt_err | output | 1 | Pulse: malformed command dropped |
| mem_rd_req | output | 1 | Word read request |
| mem_rd_addr | output | ADDR_W | Byte address of requested word |
| mem_rd_ack | input | 1 | Request accepted this cycle |
| mem_rd_vld | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data |
| cfg_valid | output | 1 | Stream word valid |
| cfg_data | output | DATA_W | Stream word |
| cfg_ready | input | 1 | Configuration port accepts word |

## Verification
The assertions assume that memory returns exactly one `mem_rd_vld` for each acknowledged request, never in the same cycle as the acknowledge, and in request order. They also assume that source lengths do not make the address wrap. The bench memory model answers only acknowledged requests, after a programmable latency of at least one cycle. It uses small, non-wrapping address ranges. The ready and acknowledge patterns are varied to exercise back-pressure on both sides without breaking those assumptions.

// File: rtl/bitload_pkg.sv
package bitload_pkg;
  typedef enum logic [1:0] {
    SEL_SRC_ADDR = 2'd0,
    SEL_DST_ADDR = 2'd1,
    SEL_SRC_LEN  = 2'd2,
    SEL_DST_LEN  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_DRAIN = 2'd2
  } eng_state_e;
endpackage

// File: rtl/bitload_cmdq_stage.sv
// Field staging and command validation (R1, R5)
module bitload_cmdq_stage import bitload_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CMD_W = 1 + (ADDR_W - 3) + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              push_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              fmt_err_o
);
  logic [ADDR_W-1:0] src_r, dst_r;
  logic [DATA_W-1:0] slen_r;
  logic              cmd_ok;

  // port-only destination, 8-byte aligned source, non-empty length
  always_comb
    cmd_ok = (src_r[2:1] == 2'b00) && (&dst_r) &&
             (wr_data == '0) && (slen_r != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_r     <= '0;
      dst_r     <= '0;
      slen_r    <= '0;
      push_o    <= 1'b0;
      fmt_err_o <= 1'b0;
      cmd_o     <= '0;
    end else begin
      push_o    <= 1'b0;
      fmt_err_o <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_SRC_ADDR: src_r  <= wr_data[ADDR_W-1:0];
          SEL_DST_ADDR: dst_r  <= wr_data[ADDR_W-1:0];
          SEL_SRC_LEN:  slen_r <= wr_data;
          SEL_DST_LEN: begin
            cmd_o <= {src_r[0], src_r[ADDR_W-1:3], slen_r};
            if (cmd_ok) push_o    <= 1'b1;
            else        fmt_err_o <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bitload_cmdq_fifo.sv
// Command queue with registered flags (R3, R4)
module bitload_cmdq_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push  = push && !full_o;
  assign do_pop   = pop && !empty_o;
  assign pop_data = mem[rd_ptr];

  always_comb begin
    cnt_nxt = cnt_q;
    if (do_push && !do_pop)      cnt_nxt = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_nxt = cnt_q - 1'b1;
  end

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt_q   <= '0;
      full_o  <= 1'b0;
      empty_o <= 1'b1;
      ovf_o   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt_q   <= cnt_nxt;
      full_o  <= (cnt_nxt == CNT_W'(DEPTH));
      empty_o <= (cnt_nxt == '0);
      ovf_o   <= push && full_o;
    end
  end
endmodule

// File: rtl/bitload_cmdq_engine.sv
// Read engine: one outstanding read, one output word slot (R2, R7, R8, R9)
module bitload_cmdq_engine import bitload_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BASE_W = ADDR_W - 3,
  localparam int CMD_W  = 1 + BASE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halted,
  input  logic              cmd_avail,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_pop,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic              mem_rd_vld,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  input  logic              word_ready,
  output logic              dma_done,
  output logic              drain_done
);
  eng_state_e        state;
  logic [DATA_W-1:0] req_left, rsp_left;
  logic              last_q, wait_q;
  logic              c_last;
  logic [BASE_W-1:0] c_base;
  logic [DATA_W-1:0] c_len;

  assign c_last  = cmd_data[CMD_W-1];
  assign c_base  = cmd_data[DATA_W +: BASE_W];
  assign c_len   = cmd_data[DATA_W-1:0];
  assign cmd_pop = (state == ENG_IDLE) && cmd_avail && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ENG_IDLE;
      req_left    <= '0;
      rsp_left    <= '0;
      last_q      <= 1'b0;
      wait_q      <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      word_valid  <= 1'b0;
      word_data   <= '0;
      dma_done    <= 1'b0;
      drain_done  <= 1'b0;
    end else begin
      dma_done   <= 1'b0;
      drain_done <= 1'b0;
      if (word_valid && word_ready) word_valid <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (cmd_pop) begin
            mem_rd_addr <= {c_base, 3'b000};
            req_left    <= c_len;
            rsp_left    <= c_len;
            last_q      <= c_last;
            state       <= ENG_FETCH;
          end
        end
        ENG_FETCH: begin
          if (mem_rd_req) begin
            if (mem_rd_ack) begin
              mem_rd_req  <= 1'b0;
              wait_q      <= 1'b1;
              mem_rd_addr <= mem_rd_addr + ADDR_W'(4);
              req_left    <= req_left - 1'b1;
            end
          end else if (!wait_q && !word_valid && req_left != '0) begin
            mem_rd_req <= 1'b1;
          end
          if (wait_q && mem_rd_vld) begin
            word_valid <= 1'b1;
            word_data  <= mem_rd_data;
            wait_q     <= 1'b0;
            rsp_left   <= rsp_left - 1'b1;
            if (rsp_left == DATA_W'(1)) begin
              if (last_q) state <= ENG_DRAIN;
              else begin
                dma_done <= 1'b1;
                state    <= ENG_IDLE;
              end
            end
          end
        end
        ENG_DRAIN: begin
          if (word_valid && word_ready) begin
            drain_done <= 1'b1;
            state      <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitload_cmdq.sv
module bitload_cmdq import bitload_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] status_o,
  output logic              halted_o,
  output logic              evt_dma_done,
  output logic              evt_drain_done,
  output logic              evt_ovf_err,
  output logic              evt_fmt_err,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic              mem_rd_vld,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              cfg_valid,
  output logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_ready
);
  localparam int CMD_W = 1 + (ADDR_W - 3) + DATA_W;

  logic             st_push, q_full, q_empty, q_pop;
  logic [CMD_W-1:0] st_cmd, q_cmd;

  bitload_cmdq_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .push_o(st_push), .cmd_o(st_cmd),
    .fmt_err_o(evt_fmt_err));

  bitload_cmdq_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(st_push), .push_data(st_cmd),
    .pop(q_pop), .pop_data(q_cmd), .full_o(q_full), .empty_o(q_empty),
    .ovf_o(evt_ovf_err));

  bitload_cmdq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .halted(halted_o), .cmd_avail(!q_empty),
    .cmd_data(q_cmd), .cmd_pop(q_pop), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .word_valid(cfg_valid), .word_data(cfg_data), .word_ready(cfg_ready),
    .dma_done(evt_dma_done), .drain_done(evt_drain_done));

  // R6: sticky halt on any error
  always_ff @(posedge clk) begin
    if (rst) halted_o <= 1'b0;
    else if (evt_ovf_err || evt_fmt_err) halted_o <= 1'b1;
  end

  // R3: flags come straight from registers
  always_comb begin
    status_o           = '0;
    status_o[DATA_W-1] = q_full;
    status_o[DATA_W-2] = q_empty;
  end
endmodule

// File: rtl/bitload_cmdq_chk.sv
module bitload_cmdq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] status_o,
  input logic              halted_o,
  input logic              evt_dma_done,
  input logic              evt_drain_done,
  input logic              evt_ovf_err,
  input logic              evt_fmt_err,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              cfg_valid,
  input logic [DATA_W-1:0] cfg_data,
  input logic              cfg_ready
);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(status_o[DATA_W-1] && status_o[DATA_W-2]));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
  a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));
  a_r7_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_dma_done, evt_drain_done}));
  a_r8_drain_after_accept: assert property (@(posedge clk) disable iff (rst)
    evt_drain_done |-> $past(cfg_valid && cfg_ready));
  a_r4_ovf_only_full: assert property (@(posedge clk) disable iff (rst)
    evt_ovf_err |-> $past(status_o[DATA_W-1]));
  a_r6_err_halts: assert property (@(posedge clk) disable iff (rst)
    (evt_ovf_err || evt_fmt_err) |=> halted_o);
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o);
endmodule

bind bitload_cmdq bitload_cmdq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .status_o(status_o), .halted_o(halted_o),
  .evt_dma_done(evt_dma_done), .evt_drain_done(evt_drain_done),
  .evt_ovf_err(evt_ovf_err), .evt_fmt_err(evt_fmt_err),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
  .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready));

// File: tb/bitload_cmdq_bench.sv
module bitload_cmdq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr_en = 1'b0;
  logic [1:0]   reg_wr_sel = 2'd0;
  logic [W-1:0] reg_wr_data = '0;
  logic [W-1:0] status_o;
  logic         halted_o, evt_dma_done, evt_drain_done, evt_ovf_err, evt_fmt_err;
  logic         mem_rd_req;
  logic [W-1:0] mem_rd_addr;
  logic         mem_rd_ack = 1'b0;
  logic         mem_rd_vld = 1'b0;
  logic [W-1:0] mem_rd_data = '0;
  logic         cfg_valid;
  logic [W-1:0] cfg_data;
  logic         cfg_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitload_cmdq #(.ADDR_W(W), .DATA_W(W), .DEPTH(4)) u_bitload_cmdq (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .status_o(status_o), .halted_o(halted_o),
    .evt_dma_done(evt_dma_done), .evt_drain_done(evt_drain_done),
    .evt_ovf_err(evt_ovf_err), .evt_fmt_err(evt_fmt_err),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_vld(mem_rd_vld), .mem_rd_data(mem_rd_data),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready));

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] exp_addr_q[$];
  logic [W-1:0] exp_word_q[$];
  int cnt_dma, cnt_drain, cnt_ovf, cnt_fmt, cnt_words, cnt_reads;
  bit mem_stall = 0;
  int ack_gap = 0, rsp_lat = 0, ready_mode = 0;
  bit rsp_pend, hold_pend;
  int rsp_cnt, wait_cnt, cyc;
  logic [W-1:0] rsp_addr, held_word;

  function automatic logic [W-1:0] word_of(input logic [W-1:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  task automatic chk_eq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory, port sink and per-clock comparison
  always @(negedge clk) begin
    if (rst) begin
      mem_rd_ack = 0; mem_rd_vld = 0; rsp_pend = 0; hold_pend = 0;
      wait_cnt = 0; cyc = 0;
    end else begin
      cyc++;
      chk_eq("R3 spare status bits", {2'b00, status_o[29:0]}, 32'h0);
      mem_rd_vld = 0;
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rd_vld = 1; mem_rd_data = word_of(rsp_addr); rsp_pend = 0;
        end else rsp_cnt--;
      end
      mem_rd_ack = 0;
      if (mem_rd_req && !mem_stall) begin
        if (wait_cnt >= ack_gap) begin
          mem_rd_ack = 1; wait_cnt = 0; cnt_reads++;
          if (exp_addr_q.size() == 0) chk_eq("R2 unexpected read", mem_rd_addr, 32'hFFFF_FFFF);
          else chk_eq("R2 read address", mem_rd_addr, exp_addr_q.pop_front());
          rsp_pend = 1; rsp_cnt = rsp_lat; rsp_addr = mem_rd_addr;
        end else wait_cnt++;
      end else if (!mem_rd_req) wait_cnt = 0;

      cfg_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (cfg_valid) begin
        if (hold_pend) chk_eq("R9 stream data held", cfg_data, held_word);
        if (cfg_ready) begin
          cnt_words++; hold_pend = 0;
          if (exp_word_q.size() == 0) chk_eq("R10 unexpected word", cfg_data, 32'hFFFF_FFFF);
          else chk_eq("R10 word order and value", cfg_data, exp_word_q.pop_front());
        end else begin
          hold_pend = 1; held_word = cfg_data;
        end
      end else if (hold_pend) begin
        chk_eq("R9 valid dropped before ready", 32'(cfg_valid), 32'h1);
        hold_pend = 0;
      end
      if (evt_dma_done) cnt_dma++;
      if (evt_ovf_err) cnt_ovf++;
      if (evt_fmt_err) cnt_fmt++;
      if (evt_drain_done) begin
        cnt_drain++;
        chk_eq("R8 drain only after final word", 32'(exp_word_q.size()), 32'h0);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1; mem_stall = 0; ack_gap = 0; rsp_lat = 0; ready_mode = 0;
    exp_addr_q.delete(); exp_word_q.delete();
    cnt_dma = 0; cnt_drain = 0; cnt_ovf = 0; cnt_fmt = 0; cnt_words = 0; cnt_reads = 0;
    settle(3);
    rst = 0;
    settle(2);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] val);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic push_cmd(input logic [W-1:0] src, input logic [W-1:0] dst,
                          input logic [W-1:0] slen, input logic [W-1:0] dlen,
                          input bit expect_run);
    if (expect_run)
      for (int i = 0; i < int'(slen); i++) begin
        exp_addr_q.push_back({src[W-1:3], 3'b000} + W'(4*i));
        exp_word_q.push_back(word_of({src[W-1:3], 3'b000} + W'(4*i)));
      end
    wr(2'd0, src); wr(2'd1, dst); wr(2'd2, slen); wr(2'd3, dlen);
  endtask

  task automatic wait_empty();
    int guard = 0;
    while ((exp_word_q.size() != 0 || cfg_valid) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    settle(6);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // reset state (R3, R6)
    do_reset();
    chk_eq("R3 status after reset", status_o, 32'h4000_0000);
    chk_eq("R6 halted after reset", 32'(halted_o), 32'h0);
    chk_eq("R2 no request after reset", 32'(mem_rd_req), 32'h0);
    chk_eq("R9 no word after reset", 32'(cfg_valid), 32'h0);

    // single final command, five words (R2, R8)
    push_cmd(32'h0000_1001, 32'hFFFF_FFFF, 5, 0, 1);
    wait_empty();
    chk_eq("R2 word count single", 32'(cnt_words), 32'd5);
    chk_eq("R8 drain pulses", 32'(cnt_drain), 32'd1);
    chk_eq("R8 no dma-done on final", 32'(cnt_dma), 32'd0);
    chk_eq("R3 empty after run", status_o, 32'h4000_0000);

    // three commands with back-pressure on both sides (R7, R9, R10)
    do_reset();
    ready_mode = 1; ack_gap = 2; rsp_lat = 3;
    push_cmd(32'h0000_4000, 32'hFFFF_FFFF, 3, 0, 1);
    push_cmd(32'h0000_5008, 32'hFFFF_FFFF, 2, 0, 1);
    push_cmd(32'h0000_6001, 32'hFFFF_FFFF, 4, 0, 1);
    wait_empty();
    chk_eq("R10 word count chain", 32'(cnt_words), 32'd9);
    chk_eq("R7 dma-done per non-final", 32'(cnt_dma), 32'd2);
    chk_eq("R8 drain once in chain", 32'(cnt_drain), 32'd1);

    // fill, overflow, halt with in-flight completion (R3, R4, R6)
    do_reset();
    mem_stall = 1;
    push_cmd(32'h0000_7000, 32'hFFFF_FFFF, 2, 0, 1);
    settle(8);
    for (int k = 0; k < 4; k++) push_cmd(32'h0000_8000 + W'(k * 64), 32'hFFFF_FFFF, 2, 0, 0);
    settle(4);
    chk_eq("R3 full flag", status_o, 32'h8000_0000);
    chk_eq("R4 no overflow yet", 32'(cnt_ovf), 32'h0);
    push_cmd(32'h0000_9000, 32'hFFFF_FFFF, 2, 0, 0);
    settle(4);
    chk_eq("R4 overflow pulse", 32'(cnt_ovf), 32'd1);
    chk_eq("R6 halted after overflow", 32'(halted_o), 32'h1);
    mem_stall = 0;
    settle(60);
    chk_eq("R6 in-flight words finish", 32'(cnt_words), 32'd2);
    chk_eq("R6 no new reads after halt", 32'(cnt_reads), 32'd2);
    chk_eq("R7 in-flight dma-done", 32'(cnt_dma), 32'd1);
    chk_eq("R6 queue untouched", status_o, 32'h8000_0000);

    // malformed commands (R5)
    for (int c = 0; c < 5; c++) begin
      do_reset();
      case (c)
        0: push_cmd(32'h0000_2004, 32'hFFFF_FFFF, 2, 0, 0);
        1: push_cmd(32'h0000_2002, 32'hFFFF_FFFF, 2, 0, 0);
        2: push_cmd(32'h0000_2000, 32'hFFFF_FFFE, 2, 0, 0);
        3: push_cmd(32'h0000_2000, 32'hFFFF_FFFF, 2, 1, 0);
        default: push_cmd(32'h0000_2000, 32'hFFFF_FFFF, 0, 0, 0);
      endcase
      settle(12);
      chk_eq("R5 format error pulse", 32'(cnt_fmt), 32'd1);
      chk_eq("R5 dropped, no reads", 32'(cnt_reads), 32'd0);
      chk_eq("R5 queue stays empty", status_o, 32'h4000_0000);
      chk_eq("R6 halted after format error", 32'(halted_o), 32'h1);
    end

    // staging writes without push, then last value wins (R1)
    do_reset();
    wr(2'd0, 32'h0000_2000); wr(2'd1, 32'hFFFF_FFFF); wr(2'd2, 32'd2);
    settle(20);
    chk_eq("R1 no push without select 3", 32'(cnt_reads), 32'd0);
    chk_eq("R1 queue empty while staging", status_o, 32'h4000_0000);
    for (int i = 0; i < 3; i++) begin
      exp_addr_q.push_back(32'h0000_3000 + W'(4*i));
      exp_word_q.push_back(word_of(32'h0000_3000 + W'(4*i)));
    end
    wr(2'd0, 32'h0000_3001); wr(2'd2, 32'd3); wr(2'd3, 32'd0);
    wait_empty();
    chk_eq("R1 pushed command words", 32'(cnt_words), 32'd3);
    chk_eq("R1 pushed command drains", 32'(cnt_drain), 32'd1);

    finish_run();
  end
endmodule